// File: doc/BRIEF.md
# Entropy Sampling Controller

This controller sits between a configuration FIFO and a bank of entropy cells. It pops a 32-bit configuration word whenever the FIFO has one. From that word it takes the length of two sampling phases, the number of 8-cell sets to combine, which of three cell banks to use, whether a von Neumann corrector is enabled, and an accumulation count that it passes on unchanged to the downstream accumulator.

Once configured, the block runs sample cycles without a break. Each cycle holds the cell assert line high for an init phase and then low for a transit phase. At the end of the transit phase it reduces the selected cells to one bit by XOR and registers that bit. The bit goes either straight into a 32-bit serial-to-parallel packer or first through the corrector. Each completed word is presented with a one-cycle valid pulse. Loading a new word restarts the phases and discards any partly built word.

Top module: `entropy_sampler_ctrl`

## Requirements
- R1: Whenever `cfg_empty` is low, `cfg_rd` is high and the word on `cfg_word` is captured at that clock edge. Its fields are: init length [3:0], transit length [7:4], last set index [12:8], source [14:13], corrector enable [15] and accumulation count [19:16]. Bits [31:20] are ignored. From the next cycle `accum_min` shows bits [19:16], and all fields hold until another word is popped.
- R2: Until the first configuration word has been captured after reset, `cell_assert` stays low and `word_valid` never pulses.
- R3: After a configuration edge, `cell_assert` is high for (init length + 1) cycles and then low for (transit length + 1) cycles, and this repeats.
- R4: At the clock edge that ends the transit phase, one bit is sampled. It is the XOR of cell sets 0 through the last set index of the selected source. Set j of source s is the XOR of `cells[(s*32+j)*8 +: 8]`.
- R5: Source codes 0, 1 and 2 select that bank. Code 3 selects bank 0.
- R6: With the corrector off, every sampled bit enters the packer MSB-first: the first bit of a word ends up in bit 31.
- R7: After 32 accepted bits, `word_data` holds the word and `word_valid` is high for exactly one cycle.
- R8: With the corrector on, samples are taken in pairs. A pair 0,1 yields 0, a pair 1,0 yields 1, and pairs 0,0 and 1,1 yield nothing. Only the yielded bits count toward a word.
- R9: Capturing a new configuration word clears the partial word, the bit count and any half-collected corrector pair, and restarts the init phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_empty | input | 1 | Configuration FIFO is empty |
| cfg_word | input | 32 | Configuration word at the FIFO head |
| cfg_rd | output | 1 | Pop strobe for the configuration FIFO |
| cells | input | 768 | Cell outputs: 3 sources x 32 sets x 8 cells |
| cell_assert | output | 1 | Assert line to the cells (high during init phase) |
| accum_min | output | 4 | Accumulation count forwarded to the post-processor |
| word_data | output | 32 | Packed random word |
| word_valid | output | 1 | One-cycle pulse marking a new word |

## Verification
Several properties are checked on every cycle by in-line assertions. The configuration fields stay stable between pops, and nothing is sampled or emitted while unconfigured. Each sample follows a cycle in which the assert line was low. An equal corrector pair leaves the bit count alone, and the valid strobe never lasts two cycles. Other behaviours can only be shown by the bench scenarios, which compare every emitted word with a model built from the requirements. These are the exact phase lengths, the choice of sets and source, the MSB-first bit order, the corrector's output values, and the discarding of a partial word when the configuration changes.

// File: rtl/entropy_sampler_ctrl.sv
module entropy_sampler_ctrl #(
  parameter int SET_CELLS = 8,
  parameter int NUM_SETS  = 32,
  parameter int NUM_SRC   = 3,
  parameter int WORD_W    = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_empty,
  input  logic [31:0]                            cfg_word,
  output logic                                   cfg_rd,
  input  logic [NUM_SRC*NUM_SETS*SET_CELLS-1:0]  cells,
  output logic                                   cell_assert,
  output logic [3:0]                             accum_min,
  output logic [WORD_W-1:0]                      word_data,
  output logic                                   word_valid
);
  localparam int SET_W = $clog2(NUM_SETS);
  localparam int CNT_W = $clog2(WORD_W);

  logic [3:0]       ph_init, ph_trans, ph_cnt;
  logic [SET_W-1:0] set_last;
  logic [1:0]       src_q;
  logic             vnc_en, configured, in_init;
  logic             bit_q, bit_v, mix;
  logic             have_first, first_bit, take, take_bit;
  logic [CNT_W-1:0] pk_cnt;
  logic [WORD_W-1:0] shreg;
  logic [NUM_SRC-1:0][NUM_SETS-1:0] set_par;

  assign cfg_rd      = !cfg_empty;
  assign cell_assert = configured && in_init;

  // configuration capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_init <= '0; ph_trans <= '0; set_last <= '0;
      src_q <= '0; vnc_en <= 1'b0; accum_min <= '0;
    end else if (cfg_rd) begin
      ph_init   <= cfg_word[3:0];
      ph_trans  <= cfg_word[7:4];
      set_last  <= cfg_word[8 +: SET_W];
      src_q     <= (cfg_word[14:13] >= 2'(NUM_SRC)) ? 2'd0 : cfg_word[14:13];
      vnc_en    <= cfg_word[15];
      accum_min <= cfg_word[19:16];
    end
  end

  // per-set parity
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    for (genvar j = 0; j < NUM_SETS; j++) begin : g_set
      assign set_par[s][j] = ^cells[(s*NUM_SETS+j)*SET_CELLS +: SET_CELLS];
    end
  end

  always_comb begin
    mix = 1'b0;
    for (int j = 0; j < NUM_SETS; j++)
      if (SET_W'(j) <= set_last) mix = mix ^ set_par[src_q][j];
  end

  // phase sequencer and output bit register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      configured <= 1'b0; in_init <= 1'b0; ph_cnt <= '0;
      bit_q <= 1'b0; bit_v <= 1'b0;
    end else if (cfg_rd) begin
      configured <= 1'b1; in_init <= 1'b1; ph_cnt <= '0; bit_v <= 1'b0;
    end else begin
      bit_v <= 1'b0;
      if (configured) begin
        if (in_init) begin
          if (ph_cnt == ph_init) begin in_init <= 1'b0; ph_cnt <= '0; end
          else ph_cnt <= ph_cnt + 4'd1;
        end else if (ph_cnt == ph_trans) begin
          in_init <= 1'b1; ph_cnt <= '0; bit_q <= mix; bit_v <= 1'b1;
        end else ph_cnt <= ph_cnt + 4'd1;
      end
    end
  end

  // corrector and packer
  assign take     = bit_v && (!vnc_en || (have_first && (first_bit != bit_q)));
  assign take_bit = vnc_en ? first_bit : bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_rd) begin
      have_first <= 1'b0; first_bit <= 1'b0; pk_cnt <= '0;
      shreg <= '0; word_valid <= 1'b0;
      if (!rst_n) word_data <= '0;
    end else begin
      word_valid <= 1'b0;
      if (bit_v && vnc_en) begin
        have_first <= !have_first;
        if (!have_first) first_bit <= bit_q;
      end
      if (take) begin
        shreg <= {shreg[WORD_W-2:0], take_bit};
        if (pk_cnt == CNT_W'(WORD_W-1)) begin
          word_data  <= {shreg[WORD_W-2:0], take_bit};
          word_valid <= 1'b1;
          pk_cnt     <= '0;
        end else pk_cnt <= pk_cnt + CNT_W'(1);
      end
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_rd) |-> $stable({accum_min, vnc_en, src_q, set_last, ph_init, ph_trans})); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !configured |-> !word_valid && !bit_v); // R2
  AST_SAMPLE_AFTER_TRANSIT: assert property (@(posedge clk) disable iff (!rst_n)
    bit_v |-> !$past(cell_assert)); // R3
  AST_SOURCE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    src_q < 2'(NUM_SRC)); // R5
  AST_BYPASS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    bit_v && !vnc_en && !cfg_rd |=> word_valid || pk_cnt == $past(pk_cnt) + CNT_W'(1)); // R6
  AST_WORD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R7
  AST_DISCARD_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    bit_v && vnc_en && have_first && (first_bit == bit_q) && !cfg_rd
    |=> $stable(pk_cnt) && !word_valid); // R8
endmodule

// File: tb/test_entropy_sampler_ctrl.sv
`timescale 1ns/1ps
module test_entropy_sampler_ctrl;
  localparam int CELL_W = 768;
  logic clk = 0, rst_n = 0, cfg_empty = 1, cfg_rd, cell_assert, word_valid;
  logic [31:0] cfg_word = '0, word_data;
  logic [CELL_W-1:0] cells = '0;
  logic [3:0] accum_min;

  entropy_sampler_ctrl i_entropy_sampler_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_empty(cfg_empty), .cfg_word(cfg_word),
    .cfg_rd(cfg_rd), .cells(cells), .cell_assert(cell_assert),
    .accum_min(accum_min), .word_data(word_data), .word_valid(word_valid));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, pushed = 0, nacc = 0;
  logic [31:0] expq[$];
  logic [31:0] acc;
  logic b_vnc, pair_have, pair_bit, last_a;
  int b_src, b_ns;
  string cur_req = "R6";

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // monitor: pops expected words as the design emits them
  always @(negedge clk) begin
    if (rst_n && word_valid) begin
      if (expq.size() == 0) chk(0, {cur_req, "/R7 unexpected word"}, word_data, 32'h0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk(word_data === e, cur_req, word_data, e);
      end
    end
  end

  task automatic send_cfg(input logic [31:0] w);
    @(negedge clk); cfg_word = w; cfg_empty = 0;
    @(negedge clk); cfg_empty = 1; cfg_word = $urandom;
    b_src = (w[14:13] == 2'd3) ? 0 : int'(w[14:13]);
    b_ns = int'(w[12:8]); b_vnc = w[15];
    nacc = 0; pair_have = 0; last_a = 1;
  endtask

  function automatic logic exp_bit();
    logic r = 0;
    for (int j = 0; j <= b_ns; j++) r ^= ^cells[(b_src*32+j)*8 +: 8];
    return r;
  endfunction

  task automatic push_bit(input logic b);
    acc = {acc[30:0], b};
    nacc++;
    if (nacc == 32) begin expq.push_back(acc); nacc = 0; pushed++; end
  endtask

  task automatic one_sample();
    logic b;
    forever begin
      @(negedge clk);
      if (last_a && !cell_assert) begin last_a = 0; break; end
      last_a = cell_assert;
    end
    for (int c = 0; c < CELL_W/32; c++) cells[c*32 +: 32] = $urandom;
    b = exp_bit();
    if (b_vnc) begin
      if (!pair_have) begin pair_have = 1; pair_bit = b; end
      else begin pair_have = 0; if (pair_bit != b) push_bit(pair_bit); end
    end else push_bit(b);
  endtask

  task automatic run_words(input int k);
    int target = pushed + k;
    while (pushed < target) one_sample();
    for (int i = 0; i < 300 && expq.size() != 0; i++) @(negedge clk);
    chk(expq.size() == 0, {cur_req, "/R7 word missing"}, expq.size(), 0);
  endtask

  task automatic chk_timing(input int ti, input int tt);
    int hi = 0, lo = 0;
    while (cell_assert && hi < 40) begin hi++; @(negedge clk); end
    while (!cell_assert && lo < 40) begin lo++; @(negedge clk); end
    chk(hi == ti + 1, "R3 init length", hi, ti + 1);
    chk(lo == tt + 1, "R3 transit length", lo, tt + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2: idle before configuration
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cell_assert || word_valid || cfg_rd) begin
        chk(0, "R2 idle", {cell_assert, word_valid, cfg_rd}, 0); break;
      end
    end
    chk(cell_assert == 0 && word_valid == 0, "R2 idle", {cell_assert, word_valid}, 0);

    // R1 field capture with reserved bits set, R3 timing
    send_cfg(32'hFFF5_0021);
    chk(accum_min == 4'h5, "R1 accum field", accum_min, 4'h5);
    chk_timing(1, 2);
    send_cfg(32'hABC5_0021);
    cur_req = "R4/R6 one set src0"; run_words(2);

    send_cfg(32'h0003_3F00);
    chk(accum_min == 4'h3, "R1 accum field", accum_min, 4'h3);
    chk_timing(0, 0);
    send_cfg(32'h0003_3F00);
    cur_req = "R4/R5 all sets src1"; run_words(2);

    send_cfg(32'h0000_4732);
    chk_timing(2, 3);
    send_cfg(32'h0000_4732);
    cur_req = "R4/R5 src2 eight sets"; run_words(2);

    send_cfg(32'h0000_6311);
    cur_req = "R5 code3 as src0"; run_words(2);

    send_cfg(32'h0000_AF11);
    cur_req = "R8 corrector"; run_words(2);

    // R9: partial word and half pair dropped on reconfiguration
    send_cfg(32'h0000_0010);
    for (int i = 0; i < 13; i++) one_sample();
    send_cfg(32'h0000_8501);
    one_sample();
    send_cfg(32'h0000_2901);
    cur_req = "R9 reconfig clears"; run_words(2);

    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R7 queue drained", expq.size(), 0);
    summary();
  end
endmodule